// File: doc/BRIEF.md
# Cipher Engine Register Front-End

This block is a word-addressed bus slave that stands between a processor bus and a block-cipher engine. Software loads a key of up to eight 32-bit words and a 128-bit input block, then starts an encryption or a decryption by setting a command bit in a single control word. The engine receives the key, the block, a key-valid flag and the command. When the engine reports completion, the block captures the 128-bit result, clears the command bit and can raise an interrupt.

Software can either poll the control word until the command bit reads back as zero, or enable the interrupt and wait for it. Clearing the key-valid flag withdraws the key and aborts any running command. A key write that arrives while the current key is valid and the engine is still expanding it is refused and flagged on `waitreq_o`. Every output, read data included, comes from a register. Reads have a latency of one cycle.

Top module: `crypto_regif`

## Requirements
- R1: After reset the control word reads 0, and `irq_o`, `waitreq_o`, `key_valid_o`, `enc_req_o` and `dec_req_o` are 0.
- R2: A write to word offset i (0 ≤ i < KEY_WORDS) sets key word i. Offset 0 is the most significant word of `key_o`. Key offsets read as 0.
- R3: Offsets 0x08–0x0B set the input block, with 0x08 the most significant word of `data_o`. These offsets read as 0.
- R4: The control word is at offset 0x1F. Bit 7 is key-valid, bit 6 is interrupt enable, bit 1 is decrypt and bit 0 is encrypt. Every other bit reads as 0. Reads return data on the cycle after the request.
- R5: A control write with bits 0 and 1 both set leaves both command bits unchanged. Encrypt and decrypt are never requested together.
- R6: When `done_i` is high while a command is active and the key is valid, the block captures `result_i`. The command bit reads 0 from the next cycle on. Offsets 0x10–0x13 return the captured result, with 0x10 the most significant word, until the next completion.
- R7: A completion sets `irq_o` on the next cycle if interrupt enable is 1. It leaves `irq_o` at 0 if interrupt enable is 0.
- R8: `irq_o` stays at 1 until a read of any offset 0x10–0x13, or until a control write with bit 6 at 0. Reads of other offsets do not clear it.
- R9: A key-range write while key-valid is 1 and `key_busy_i` is 1 is discarded. `waitreq_o` is 1 on the following cycle. With key-valid at 0, the same write is accepted.
- R10: A control write with bit 7 at 0 clears both command bits. This aborts the running command without a completion.
- R11: Writes to the result offsets or to reserved offsets (0x0C–0x0F, 0x14–0x1E) change nothing. Reserved offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Word offset |
| wdata_i | input | 32 | Write data |
| write_i | input | 1 | Write strobe |
| read_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the cycle after `read_i` |
| waitreq_o | output | 1 | Previous key write was refused |
| irq_o | output | 1 | Completion interrupt |
| key_o | output | 32*KEY_WORDS | Key to the engine, word 0 most significant |
| data_o | output | 128 | Input block to the engine |
| key_valid_o | output | 1 | Key-valid flag |
| enc_req_o | output | 1 | Encrypt command |
| dec_req_o | output | 1 | Decrypt command |
| key_busy_i | input | 1 | Engine is still expanding the key |
| done_i | input | 1 | Engine completion pulse |
| result_i | input | 128 | Engine result |

## Verification
Directed sequences cover the corner cases:
- the control write with both command bits set, alone and over an active command;
- a key write while the key is valid and the engine is busy, then the same write with key-valid low;
- an abort with no completion;
- interrupt clearing by result read, by non-result read and by disabling the interrupt.

Randomised rounds then draw a key, a block, an operation and an interrupt enable for each round. The bench drives a completion with a result that it computes itself. Mismatches in word ordering, in the capture of the result and in the interrupt's dependence on the enable bit therefore all show up as distinct failures.

// File: rtl/crypto_regif_pkg.sv
package crypto_regif_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;
  localparam int unsigned BLK_WORDS = 4;
  localparam int CB_KV  = 7;
  localparam int CB_IE  = 6;
  localparam int CB_DEC = 1;
  localparam int CB_ENC = 0;

  typedef enum logic [2:0] {RG_KEY, RG_DATA, RG_RES, RG_CTRL, RG_NONE} region_e;

  function automatic region_e decode(logic [AW-1:0] a);
    case (a[4:3])
      2'd0:    return RG_KEY;
      2'd1:    return a[2] ? RG_NONE : RG_DATA;
      2'd2:    return a[2] ? RG_NONE : RG_RES;
      default: return (a == 5'h1f) ? RG_CTRL : RG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/regif_ctrl.sv
module regif_ctrl
  import crypto_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  input  logic          rd_res_i,
  output logic          kv_o,
  output logic          ie_o,
  output logic          enc_o,
  output logic          dec_o,
  output logic          irq_o,
  output logic          cap_o
);
  logic kv_q, ie_q, enc_q, dec_q, irq_q;
  logic fin;

  assign fin = done_i & (enc_q | dec_q) & kv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kv_q <= 1'b0; ie_q <= 1'b0; enc_q <= 1'b0; dec_q <= 1'b0;
    end else begin
      if (fin) begin
        enc_q <= 1'b0;
        dec_q <= 1'b0;
      end
      if (wr_ctrl_i) begin
        kv_q <= wdata_i[CB_KV];
        ie_q <= wdata_i[CB_IE];
        // both command bits set: keep current command
        if (!(wdata_i[CB_ENC] & wdata_i[CB_DEC])) begin
          enc_q <= wdata_i[CB_ENC];
          dec_q <= wdata_i[CB_DEC];
        end
        if (!wdata_i[CB_KV]) begin
          enc_q <= 1'b0;
          dec_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         irq_q <= 1'b0;
    else if (wr_ctrl_i && !wdata_i[CB_IE]) irq_q <= 1'b0;
    else if (fin && ie_q)                irq_q <= 1'b1;
    else if (rd_res_i)                   irq_q <= 1'b0;
  end

  assign kv_o  = kv_q;
  assign ie_o  = ie_q;
  assign enc_o = enc_q;
  assign dec_o = dec_q;
  assign irq_o = irq_q;
  assign cap_o = fin;
endmodule

// File: rtl/regif_store.sv
module regif_store
  import crypto_regif_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_key_i,
  input  logic                      wr_data_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      cap_i,
  input  logic [BLK_WORDS*DW-1:0]   result_i,
  output logic [KEY_WORDS*DW-1:0]   key_o,
  output logic [BLK_WORDS*DW-1:0]   data_o,
  output logic [BLK_WORDS*DW-1:0]   res_o
);
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    logic [DW-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q <= '0;
      else if (wr_key_i && addr_i == AW'(i)) w_q <= wdata_i;
    end
    assign key_o[(KEY_WORDS-1-i)*DW +: DW] = w_q;
  end

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_data
    logic [DW-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q <= '0;
      else if (wr_data_i && addr_i[1:0] == 2'(i)) w_q <= wdata_i;
    end
    assign data_o[(BLK_WORDS-1-i)*DW +: DW] = w_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (cap_i) res_o <= result_i;
  end
endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
  import crypto_regif_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    read_i,
  input  region_e                 region_i,
  input  logic [1:0]              word_i,
  input  logic [BLK_WORDS*DW-1:0] res_i,
  input  logic [3:0]              ctrl_i,
  output logic [DW-1:0]           rdata_o
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    case (region_i)
      RG_RES:  sel = res_i[(BLK_WORDS-1-int'(word_i))*DW +: DW];
      RG_CTRL: begin
        sel[CB_KV]  = ctrl_i[3];
        sel[CB_IE]  = ctrl_i[2];
        sel[CB_DEC] = ctrl_i[1];
        sel[CB_ENC] = ctrl_i[0];
      end
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= read_i ? sel : '0;
  end
endmodule

// File: rtl/crypto_regif.sv
module crypto_regif
  import crypto_regif_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [4:0]                 addr_i,
  input  logic [31:0]                wdata_i,
  input  logic                       write_i,
  input  logic                       read_i,
  output logic [31:0]                rdata_o,
  output logic                       waitreq_o,
  output logic                       irq_o,
  output logic [32*KEY_WORDS-1:0]    key_o,
  output logic [127:0]               data_o,
  output logic                       key_valid_o,
  output logic                       enc_req_o,
  output logic                       dec_req_o,
  input  logic                       key_busy_i,
  input  logic                       done_i,
  input  logic [127:0]               result_i
);
  region_e region;
  logic kv, ie, enc, dec, cap, key_lock, wr_key_hit;
  logic [BLK_WORDS*DW-1:0] res;

  assign region     = decode(addr_i);
  assign key_lock   = kv & key_busy_i;
  assign wr_key_hit = write_i & (region == RG_KEY);

  regif_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_ctrl_i (write_i & (region == RG_CTRL)),
    .wdata_i,
    .done_i,
    .rd_res_i  (read_i & (region == RG_RES)),
    .kv_o      (kv),
    .ie_o      (ie),
    .enc_o     (enc),
    .dec_o     (dec),
    .irq_o     (irq_o),
    .cap_o     (cap)
  );

  regif_store #(.KEY_WORDS(KEY_WORDS)) u_store (
    .clk_i, .rst_ni,
    .wr_key_i  (wr_key_hit & ~key_lock),
    .wr_data_i (write_i & (region == RG_DATA)),
    .addr_i,
    .wdata_i,
    .cap_i     (cap),
    .result_i,
    .key_o,
    .data_o,
    .res_o     (res)
  );

  regif_rdmux u_rdmux (
    .clk_i, .rst_ni,
    .read_i,
    .region_i  (region),
    .word_i    (addr_i[1:0]),
    .res_i     (res),
    .ctrl_i    ({kv, ie, dec, enc}),
    .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) waitreq_o <= 1'b0;
    else         waitreq_o <= wr_key_hit & key_lock;
  end

  assign key_valid_o = kv;
  assign enc_req_o   = enc;
  assign dec_req_o   = dec;
endmodule

// File: rtl/crypto_regif_chk.sv
module crypto_regif_chk #(
  parameter int unsigned KEY_WORDS = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [4:0]              addr_i,
  input logic                    write_i,
  input logic                    read_i,
  input logic [31:0]             rdata_o,
  input logic                    waitreq_o,
  input logic                    irq_o,
  input logic [32*KEY_WORDS-1:0] key_o,
  input logic                    key_valid_o,
  input logic                    enc_req_o,
  input logic                    dec_req_o,
  input logic                    done_i
);
  logic rsvd;
  assign rsvd = (addr_i[4:2] == 3'b011) || (addr_i >= 5'h14 && addr_i <= 5'h1e);

  p_cmd_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enc_req_o && dec_req_o));

  p_done_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && key_valid_o && (enc_req_o || dec_req_o) && !write_i |=> !enc_req_o && !dec_req_o);

  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i));

  p_key_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waitreq_o |-> $stable(key_o));

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_o |-> !enc_req_o && !dec_req_o);

  p_rsvd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i && rsvd |=> rdata_o == 32'h0);
endmodule

bind crypto_regif crypto_regif_chk #(.KEY_WORDS(KEY_WORDS)) u_chk (
  .clk_i, .rst_ni, .addr_i, .write_i, .read_i, .rdata_o, .waitreq_o,
  .irq_o, .key_o, .key_valid_o, .enc_req_o, .dec_req_o, .done_i
);

// File: tb/crypto_regif_tb.sv
module crypto_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic write_i = 1'b0, read_i = 1'b0;
  logic [31:0] rdata_o;
  logic waitreq_o, irq_o, key_valid_o, enc_req_o, dec_req_o;
  logic [32*KW-1:0] key_o;
  logic [127:0] data_o;
  logic key_busy_i = 1'b0, done_i = 1'b0;
  logic [127:0] result_i = '0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crypto_regif #(.KEY_WORDS(KW)) u_dut (.*);

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; write_i = 1'b1;
    @(negedge clk_i); write_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; read_i = 1'b1;
    @(negedge clk_i); read_i = 1'b0; d = rdata_o;
  endtask

  task automatic finish_op(logic [127:0] r);
    @(negedge clk_i); done_i = 1'b1; result_i = r;
    @(negedge clk_i); done_i = 1'b0;
  endtask

  function automatic logic [127:0] model_res(logic [127:0] blk, bit dec, int iter);
    return blk ^ {4{dec ? 32'h5a5a_5a5a : 32'h0f0f_0f0f}} ^ 128'(iter);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] kw [KW];
    logic [127:0] blk, r, key_before;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(5'h1f, d); check("R1 ctrl", d, 0);
    check("R1 outs", {irq_o, waitreq_o, key_valid_o, enc_req_o, dec_req_o}, 0);

    // R2 key order
    for (int i = 0; i < KW; i++) begin kw[i] = 32'h1100_0000 + i; wr(5'(i), kw[i]); end
    check("R2 key_o", key_o, {kw[0], kw[1], kw[2], kw[3], kw[4], kw[5], kw[6], kw[7]});
    rd(5'h03, d); check("R2 key read zero", d, 0);

    // R3 data order
    for (int i = 0; i < 4; i++) wr(5'(8+i), 32'hd000_0000 + i);
    check("R3 data_o", data_o, {32'hd000_0000, 32'hd000_0001, 32'hd000_0002, 32'hd000_0003});
    rd(5'h09, d); check("R3 data read zero", d, 0);

    // R4 control bits
    wr(5'h1f, 32'hffff_fffc); rd(5'h1f, d); check("R4 ctrl mask", d, 32'hc0);
    wr(5'h1f, 32'h0); rd(5'h1f, d); check("R4 ctrl clear", d, 0);

    // R5 both command bits
    wr(5'h1f, 32'h83); rd(5'h1f, d); check("R5 both idle", d, 32'h80);
    check("R5 no req", {enc_req_o, dec_req_o}, 2'b00);
    wr(5'h1f, 32'h81); wr(5'h1f, 32'h83); rd(5'h1f, d); check("R5 both keeps enc", d, 32'h81);
    check("R5 enc only", {enc_req_o, dec_req_o}, 2'b10);

    // R6 completion, R7 no irq when disabled
    r = 128'hcafe_0001_cafe_0002_cafe_0003_cafe_0004;
    finish_op(r);
    check("R6 enc cleared", enc_req_o, 0);
    check("R7 irq off", irq_o, 0);
    rd(5'h1f, d); check("R6 ctrl after done", d, 32'h80);
    rd(5'h10, d); check("R6 res msw", d, 32'hcafe_0001);
    rd(5'h13, d); check("R6 res lsw", d, 32'hcafe_0004);

    // R11 ignored writes / reserved reads
    wr(5'h10, 32'hdead_beef); wr(5'h0c, 32'hdead_beef); wr(5'h15, 32'hdead_beef);
    rd(5'h10, d); check("R11 res unchanged", d, 32'hcafe_0001);
    check("R11 data unchanged", data_o, {32'hd000_0000, 32'hd000_0001, 32'hd000_0002, 32'hd000_0003});
    rd(5'h15, d); check("R11 reserved read", d, 0);
    rd(5'h0e, d); check("R11 reserved read2", d, 0);

    // R9 refused key write
    key_before = key_o[127:0];
    key_busy_i = 1'b1;
    wr(5'h07, 32'h7777_7777);
    check("R9 waitreq", waitreq_o, 1);
    check("R9 key kept", key_o[31:0], kw[7]);
    @(negedge clk_i); check("R9 waitreq drops", waitreq_o, 0);
    wr(5'h1f, 32'h0);
    wr(5'h07, 32'h7777_7777);
    check("R9 accepted kv low", key_o[31:0], 32'h7777_7777);
    check("R9 no wait kv low", waitreq_o, 0);
    key_busy_i = 1'b0;

    // R10 abort
    wr(5'h1f, 32'h82); check("R10 dec running", dec_req_o, 1);
    wr(5'h1f, 32'h02); check("R10 aborted", {enc_req_o, dec_req_o, key_valid_o}, 3'b000);
    rd(5'h1f, d); check("R10 ctrl", d, 0);
    check("R10 irq none", irq_o, 0);

    // R8 irq clearing
    wr(5'h1f, 32'hc1); finish_op(128'h1);
    check("R7 irq set", irq_o, 1);
    rd(5'h1f, d); check("R8 ctrl read keeps irq", irq_o, 1);
    rd(5'h11, d); check("R8 res read clears", irq_o, 0);
    wr(5'h1f, 32'hc2); finish_op(128'h2);
    check("R7 irq set dec", irq_o, 1);
    wr(5'h1f, 32'h80); check("R8 ie clear", irq_o, 0);

    // randomised rounds
    void'($urandom(32'h1234));
    for (int it = 0; it < 40; it++) begin
      bit dec, ie;
      logic [31:0] kr [KW];
      logic [31:0] br [4];
      dec = 1'($urandom); ie = 1'($urandom);
      wr(5'h1f, 32'h0);
      for (int i = 0; i < KW; i++) begin kr[i] = $urandom; wr(5'(i), kr[i]); end
      for (int i = 0; i < 4; i++) begin br[i] = $urandom; wr(5'(8+i), br[i]); end
      blk = {br[0], br[1], br[2], br[3]};
      check("R2 rand key", key_o, {kr[0], kr[1], kr[2], kr[3], kr[4], kr[5], kr[6], kr[7]});
      check("R3 rand data", data_o, blk);
      wr(5'h1f, {24'h0, 1'b1, ie, 4'h0, dec, ~dec});
      check("R4 rand req", {enc_req_o, dec_req_o}, {~dec, dec});
      r = model_res(blk, dec, it);
      finish_op(r);
      rd(5'h1f, d); check("R6 rand ctrl", d, {24'h0, 1'b1, ie, 6'h0});
      check("R7 rand irq", irq_o, ie);
      for (int i = 0; i < 4; i++) begin
        rd(5'(16+i), d); check("R6 rand res", d, r[(3-i)*32 +: 32]);
      end
      check("R8 rand irq cleared", irq_o, 0);
    end

    summary();
  end
endmodule